// File: doc/BRIEF.md
# Pulse-Synchronized Phase Energy Snapshot

This block keeps running energy totals for three phases and three kinds of power (active, reactive, apparent). Every clock it adds a signed increment to each of the nine totals. It watches an active-low pulse output, such as the one an energy-to-frequency divider produces. After a programmed number of high-to-low transitions on that pulse, it copies the three phase totals of one chosen power type into three hold registers and clears those totals. Software then reads the energy that was delivered during a known number of output pulses.

The feature is gated by an enable bit and a 3-bit type select. The three phase totals of the selected type are always captured together. The latch-and-clear is counted in pulse edges, never timed. The other two power types keep accumulating until they are selected.

Top module: `pulse_sync_energy_latch`

## Requirements
- R1: A latch is triggered only by a high-to-low transition of `pulse_n_i`, which is seen as input high at one clock edge and low at the next. A rising edge or a steady level never triggers a latch.
- R2: With the feature active, the latch fires on the N-th falling edge after the previous reload, where N is the 8-bit unsigned `cyc_cnt_i` (1 to 255).
- R3: A cycle count of 0 behaves exactly like a count of 1.
- R4: On a latch, `hold_o` phase p (bits p*AW +: AW, phase 0 in the LSBs) takes the selected type's phase-p total as it stood before that clock's increment, and that total is cleared. `hold_o` changes at no other time.
- R5: An increment presented in the latching clock is added to the freshly cleared total, so no energy is lost.
- R6: The totals of the two unselected types are neither latched nor cleared. They keep accumulating and show their full sums once they are selected and latched.
- R7: With `sync_en_i` = 0 no latch occurs. The edge counter is held at its reload value, so counting starts fresh when the feature is enabled.
- R8: The select encodings are 000 = active, 001 = reactive and 010 = apparent. Any value from 011 to 111 blocks latching in the same way as R7.
- R9: The edge counter is reloaded from `cyc_cnt_i` at every latch and whenever the feature is inactive. A change to `cyc_cnt_i` in the middle of a count takes effect only at the next reload.
- R10: `latch_done_o` is high for exactly the one cycle in which the new `hold_o` value first appears.
- R11: After reset, `hold_o` and all totals are 0, `latch_done_o` is 0, and the pulse is taken to be high.
- R12: Increments are sign-extended IW-bit values. Totals wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pulse_n_i | input | 1 | Active-low pulse output being counted |
| sync_en_i | input | 1 | Enables synchronized latching |
| type_sel_i | input | 3 | Power type to latch: 0 active, 1 reactive, 2 apparent |
| cyc_cnt_i | input | 8 | Falling edges between latches (0 means 1) |
| inc_act_i | input | 3*IW | Signed active-energy increments, phase 0 in LSBs |
| inc_rea_i | input | 3*IW | Signed reactive-energy increments |
| inc_app_i | input | 3*IW | Signed apparent-energy increments |
| hold_o | output | 3*AW | Latched phase totals, phase 0 in LSBs |
| latch_done_o | output | 1 | One-cycle strobe on a hold update |

## Verification
The assertions assume that `pulse_n_i` is a synchronous signal that sits high while reset is active. Under that assumption the edge detector's reset value of "high" matches the real input, and any strobe can be traced back to a genuine high-then-low pair two samples earlier. The bench drives the pulse only at the falling clock edge and holds it high through reset. Its high and low phases are generated with random lengths of at least one cycle, so every edge is a clean one-sample transition. The enable, select and cycle count are changed only between clock edges. The random increments cover the full signed range, which makes sign extension and wrap visible within a short run.

// File: rtl/pse_pkg.sv
package pse_pkg;

  localparam int unsigned NTYPE = 3;

  typedef enum logic [2:0] {
    SEL_ACTIVE   = 3'd0,
    SEL_REACTIVE = 3'd1,
    SEL_APPARENT = 3'd2
  } pwr_sel_e;

  function automatic logic sel_valid(input logic [2:0] sel);
    return (sel == SEL_ACTIVE) || (sel == SEL_REACTIVE) || (sel == SEL_APPARENT);
  endfunction

endpackage

// File: rtl/pse_edge_counter.sv
module pse_edge_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_n_i,
  input  logic          active_i,
  input  logic [CW-1:0] cyc_i,
  output logic          latch_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          pulse_q;
  logic [CW-1:0] rem_q, rem_d;
  logic [CW-1:0] reload_val, rem_eff;
  logic          fall;

  // zero count stands for one; zero in rem_q marks "not yet loaded"
  assign reload_val = (cyc_i == '0) ? ONE : cyc_i;
  assign rem_eff    = (rem_q == '0) ? reload_val : rem_q;
  assign fall       = pulse_q & ~pulse_n_i;

  always_comb begin
    latch_o = 1'b0;
    rem_d   = rem_eff;
    if (!active_i) begin
      rem_d = reload_val;
    end else if (fall) begin
      if (rem_eff == ONE) begin
        latch_o = 1'b1;
        rem_d   = reload_val;
      end else begin
        rem_d = rem_eff - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b1;
      rem_q   <= '0;
    end else begin
      pulse_q <= pulse_n_i;
      rem_q   <= rem_d;
    end
  end

endmodule

// File: rtl/pse_accum_bank.sv
module pse_accum_bank #(
  parameter int unsigned NPH = 3,
  parameter int unsigned IW  = 16,
  parameter int unsigned AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPH*IW-1:0] inc_i,
  input  logic              clr_i,
  output logic [NPH*AW-1:0] acc_o
);

  localparam int unsigned EXT = AW - IW;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [IW-1:0] inc_raw;
    logic [AW-1:0] inc_ext, base, acc_q, acc_d;

    assign inc_raw = inc_i[p*IW +: IW];
    assign inc_ext = {{EXT{inc_raw[IW-1]}}, inc_raw};
    // clear and add in one step so a same-cycle increment survives
    assign base    = clr_i ? '0 : acc_q;
    assign acc_d   = base + inc_ext;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else begin
        acc_q <= acc_d;
      end
    end

    assign acc_o[p*AW +: AW] = acc_q;
  end

endmodule

// File: rtl/pse_hold_bank.sv
module pse_hold_bank #(
  parameter int unsigned NPH = 3,
  parameter int unsigned AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_i,
  input  logic [NPH*AW-1:0] acc_sel_i,
  output logic [NPH*AW-1:0] hold_o,
  output logic              done_o
);

  logic [NPH*AW-1:0] hold_q, hold_d;
  logic              done_q;

  always_comb begin
    hold_d = hold_q;
    if (latch_i) hold_d = acc_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      done_q <= latch_i;
    end
  end

  assign hold_o = hold_q;
  assign done_o = done_q;

endmodule

// File: rtl/pulse_sync_energy_latch.sv
module pulse_sync_energy_latch
  import pse_pkg::*;
#(
  parameter int unsigned NPH = 3,
  parameter int unsigned IW  = 16,
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_n_i,
  input  logic              sync_en_i,
  input  logic [2:0]        type_sel_i,
  input  logic [CW-1:0]     cyc_cnt_i,
  input  logic [NPH*IW-1:0] inc_act_i,
  input  logic [NPH*IW-1:0] inc_rea_i,
  input  logic [NPH*IW-1:0] inc_app_i,
  output logic [NPH*AW-1:0] hold_o,
  output logic              latch_done_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic              active, latch;
  logic [NPH*IW-1:0] inc_by_type [NTYPE];
  logic [NPH*AW-1:0] acc_by_type [NTYPE];
  logic [NPH*AW-1:0] acc_sel;

  assign active = sync_en_i & sel_valid(type_sel_i);

  assign inc_by_type[0] = inc_act_i;
  assign inc_by_type[1] = inc_rea_i;
  assign inc_by_type[2] = inc_app_i;

  pse_edge_counter #(.CW(CW)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pulse_n_i (pulse_n_i),
    .active_i  (active),
    .cyc_i     (cyc_cnt_i),
    .latch_o   (latch)
  );

  for (genvar t = 0; t < NTYPE; t++) begin : g_type
    logic clr;
    assign clr = latch && (type_sel_i == 3'(t));

    pse_accum_bank #(.NPH(NPH), .IW(IW), .AW(AW)) bank_i (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc_i (inc_by_type[t]),
      .clr_i (clr),
      .acc_o (acc_by_type[t])
    );
  end

  always_comb begin
    unique case (type_sel_i)
      SEL_ACTIVE:   acc_sel = acc_by_type[0];
      SEL_REACTIVE: acc_sel = acc_by_type[1];
      SEL_APPARENT: acc_sel = acc_by_type[2];
      default:      acc_sel = '0;
    endcase
  end

  pse_hold_bank #(.NPH(NPH), .AW(AW)) hold_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .latch_i   (latch),
    .acc_sel_i (acc_sel),
    .hold_o    (hold_o),
    .done_o    (latch_done_o)
  );

endmodule

// File: rtl/pse_latch_chk.sv
module pse_latch_chk #(
  parameter int unsigned NPH = 3,
  parameter int unsigned AW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_n_i,
  input logic              sync_en_i,
  input logic [2:0]        type_sel_i,
  input logic [NPH*AW-1:0] hold_o,
  input logic              latch_done_o
);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_done_o |=> !latch_done_o);

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_done_o |-> $stable(hold_o));

  p_fall_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_done_o |-> ($past(pulse_n_i, 2) && !$past(pulse_n_i)));

  p_en_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_done_o |-> $past(sync_en_i));

  p_sel_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_done_o |-> ($past(type_sel_i) <= 3'd2));

endmodule

bind pulse_sync_energy_latch pse_latch_chk #(.NPH(NPH), .AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .pulse_n_i    (pulse_n_i),
  .sync_en_i    (sync_en_i),
  .type_sel_i   (type_sel_i),
  .hold_o       (hold_o),
  .latch_done_o (latch_done_o)
);

// File: tb/pulse_sync_energy_latch_tb_top.sv
`timescale 1ns/1ps
module pulse_sync_energy_latch_tb_top;

  localparam int NPH = 3;
  localparam int IW  = 16;
  localparam int AW  = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              pulse_n;
  logic              en;
  logic [2:0]        sel;
  logic [7:0]        cyc;
  logic [IW-1:0]     inc [3][NPH];
  logic [NPH*IW-1:0] inc_act, inc_rea, inc_app;
  logic [NPH*AW-1:0] hold;
  logic              done;

  assign inc_act = {inc[0][2], inc[0][1], inc[0][0]};
  assign inc_rea = {inc[1][2], inc[1][1], inc[1][0]};
  assign inc_app = {inc[2][2], inc[2][1], inc[2][0]};

  pulse_sync_energy_latch #(.NPH(NPH), .IW(IW), .AW(AW), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_n_i(pulse_n), .sync_en_i(en),
    .type_sel_i(sel), .cyc_cnt_i(cyc), .inc_act_i(inc_act),
    .inc_rea_i(inc_rea), .inc_app_i(inc_app), .hold_o(hold),
    .latch_done_o(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [AW-1:0] m_acc [3][NPH];
  logic [AW-1:0] m_hold [NPH];
  logic          m_prev, m_done;
  int            m_rem;
  int            latch_seen;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 3; t++) for (int p = 0; p < NPH; p++) m_acc[t][p] = '0;
    for (int p = 0; p < NPH; p++) m_hold[p] = '0;
    m_prev = 1'b1; m_done = 1'b0; m_rem = 0;
  endtask

  task automatic model_step();
    bit fall, act, lat;
    int eff, rem_e;
    fall = m_prev && !pulse_n;
    m_prev = pulse_n;
    act = en && (sel <= 3'd2);
    eff = (cyc == 0) ? 1 : int'(cyc);
    rem_e = (m_rem == 0) ? eff : m_rem;
    lat = 1'b0;
    if (!act) m_rem = eff;
    else if (fall) begin
      if (rem_e == 1) begin lat = 1'b1; m_rem = eff; end
      else m_rem = rem_e - 1;
    end else m_rem = rem_e;
    if (lat) begin
      for (int p = 0; p < NPH; p++) begin
        m_hold[p] = m_acc[sel][p];
        m_acc[sel][p] = '0;
      end
    end
    for (int t = 0; t < 3; t++)
      for (int p = 0; p < NPH; p++)
        m_acc[t][p] = m_acc[t][p] + {{(AW-IW){inc[t][p][IW-1]}}, inc[t][p]};
    m_done = lat;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    if (done) latch_seen++;
    check(tag, 64'(done), 64'(m_done), "latch_done");
    for (int p = 0; p < NPH; p++)
      check(tag, 64'(hold[p*AW +: AW]), 64'(m_hold[p]), $sformatf("hold ph%0d", p));
  endtask

  task automatic set_inc(int mode);
    for (int t = 0; t < 3; t++)
      for (int p = 0; p < NPH; p++)
        case (mode)
          0: inc[t][p] = '0;
          1: inc[t][p] = IW'($urandom);
          default: inc[t][p] = 16'h7fff;
        endcase
  endtask

  // one pulse period: high then low, each for a random 1..hmax cycles
  task automatic pulse_edges(int n, int mode, int hmax, string tag);
    for (int e = 0; e < n; e++) begin
      int hi, lo;
      hi = 1 + int'($urandom % hmax);
      lo = 1 + int'($urandom % hmax);
      for (int c = 0; c < hi; c++) begin pulse_n = 1'b1; set_inc(mode); step(tag); end
      for (int c = 0; c < lo; c++) begin pulse_n = 1'b0; set_inc(mode); step(tag); end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pulse_n = 1'b1; en = 1'b0; sel = 3'd0; cyc = 8'd1;
    set_inc(0);
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11", 64'(done), 64'd0, "latch_done after reset");
    check("R11", 64'(hold), 64'd0, "hold after reset");
    en = 1'b1; sel = 3'd0; cyc = 8'd1;
    pulse_edges(1, 0, 2, "R11");

    // R1 rising edge and long low level do nothing extra
    pulse_n = 1'b1; set_inc(1); step("R1");
    for (int c = 0; c < 6; c++) begin pulse_n = 1'b0; set_inc(1); step("R1"); end
    for (int c = 0; c < 6; c++) begin pulse_n = 1'b1; set_inc(1); step("R1"); end

    // R2 counting with several counts, R4/R5 random increments
    latch_seen = 0;
    cyc = 8'd3; pulse_edges(9, 1, 3, "R2");
    check("R2", 64'(latch_seen), 64'd3, "latches over 9 edges at count 3");
    cyc = 8'd5; pulse_edges(10, 1, 2, "R4");
    cyc = 8'd1; pulse_edges(6, 1, 3, "R5");

    // R3 zero count
    latch_seen = 0;
    cyc = 8'd0; pulse_edges(4, 1, 2, "R3");
    check("R3", 64'(latch_seen), 64'd4, "latches with count 0");

    // R9 change count mid-way
    cyc = 8'd4; pulse_edges(2, 1, 2, "R9");
    cyc = 8'd1; pulse_edges(4, 1, 2, "R9");

    // R7 disabled
    en = 1'b0; latch_seen = 0; pulse_edges(5, 1, 2, "R7");
    check("R7", 64'(latch_seen), 64'd0, "latches while disabled");
    en = 1'b1; cyc = 8'd2; pulse_edges(4, 1, 2, "R7");

    // R8 invalid selects
    latch_seen = 0;
    for (int s = 3; s < 8; s++) begin sel = 3'(s); pulse_edges(2, 1, 2, "R8"); end
    check("R8", 64'(latch_seen), 64'd0, "latches with invalid select");

    // R6 other types kept their full sums
    sel = 3'd1; cyc = 8'd1; pulse_edges(3, 1, 2, "R6");
    sel = 3'd2; pulse_edges(3, 1, 2, "R6");

    // R12 wrap with maximum increments
    sel = 3'd0; cyc = 8'd40; pulse_edges(80, 2, 2, "R12");
    cyc = 8'd3; pulse_edges(30, 1, 4, "R10");

    // random mix
    for (int k = 0; k < 60; k++) begin
      en  = ($urandom % 8) != 0;
      sel = 3'($urandom % 4);
      cyc = 8'($urandom % 5);
      pulse_edges(3, 1, 3, "R4");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule